// File: doc/BRIEF.md
# Dynamic RAM Controller with Refresh

This block sits between a single requester and a bank of dynamic RAM with a 14-bit word address. When the requester raises a read or write request while the controller is selected, the controller opens a row, then a column, on one shared set of seven address pins. It drives the row strobe, the column strobe and the write enable, and then reports back with two acknowledges, all active low. The early acknowledge tells the requester that its memory cycle has started. The late acknowledge tells it that the cycle has completed and read data is valid. The requester keeps its request up until it sees the late acknowledge, and then drops it to end the cycle.

An interval counter inside the block keeps the array refreshed without help from the requester. Each time the counter expires, the controller runs one refresh cycle in which only the row strobe is asserted. During that cycle a 7-bit refresh row counter drives the address pins. An access that arrives while a refresh is running waits until the refresh and its precharge have finished. When this happens, the early acknowledge is not given at the start of the cycle and instead falls together with the late acknowledge. A mode input can switch automatic refresh off completely.

Top module: `dram_ctl`

## Requirements
- R1: In the first cycle of an access, ras_n is low, cas_n is high and ram_addr carries addr[6:0].
- R2: In the second cycle, ras_n and cas_n are both low and ram_addr carries addr[13:7]. cas_n stays low until the request is dropped.
- R3: On a write, we_n is low in the first and second cycles and high from the third cycle on. On a read, we_n stays high throughout.
- R4: If no refresh was running while the request waited, early_ack_n is low from the first cycle of the access. If a refresh was running, early_ack_n stays high until the cycle in which late_ack_n falls.
- R5: late_ack_n goes low in the third cycle of the access. From that cycle on, both acknowledges stay low for as long as the request is held.
- R6: One cycle after the request is dropped, both acknowledges, ras_n and cas_n are high again.
- R7: While sel is low, read and write requests are ignored, and ras_n does not fall for them.
- R8: With auto_ref high, a refresh starts every REF_INTERVAL cycles while the controller is idle. A refresh holds ras_n low with cas_n and we_n high for REF_CYC cycles and places the refresh row on ram_addr. The refresh row starts at 0 after reset and increments by one, modulo 128, after each refresh.
- R9: With auto_ref low, no refresh cycles occur.
- R10: An access that arrives during a refresh starts only after the refresh has finished. ras_n is high in the cycle before the access row cycle.
- R11: A refresh that falls due during an access runs after that access completes and before the next access starts. This ensures that refresh keeps running under back-to-back traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Chip select, active high |
| rd_req | input | 1 | Read request, held until the late acknowledge is seen |
| wr_req | input | 1 | Write request, held until the late acknowledge is seen |
| addr | input | 14 | Word address; the low 7 bits are the row and the high 7 bits are the column |
| auto_ref | input | 1 | 1 enables automatic refresh |
| ram_addr | output | 7 | Multiplexed RAM address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| early_ack_n | output | 1 | Cycle-started acknowledge, active low |
| late_ack_n | output | 1 | Cycle-complete acknowledge, active low |

## Verification
The assertions assume the requester handshake described above. A request stays up without a change of direction or address until late_ack_n falls. rd_req and wr_req are never raised together. The stimulus keeps within these assumptions because all traffic comes from a single access task: it drives one direction with a fixed address, waits for the late acknowledge, holds for a random number of cycles and only then drops the request. Random gaps between accesses, from zero to about twenty cycles, shift refresh expiries into every phase of an access, so the withheld early acknowledge and the ordering of a refresh after an access both occur without directed timing.

// File: rtl/dram_pkg.sv
package dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_DATA,
        ST_PRE,
        ST_REF,
        ST_REFPRE
    } dram_st_e;

    typedef enum logic [1:0] {
        PIN_ROW,
        PIN_COL,
        PIN_REF,
        PIN_NONE
    } pin_src_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int INTERVAL = 64,
    parameter int ROW_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             take,
    input  logic             advance,
    output logic             pend,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (take) begin
            tmr_d.pend = 1'b0;
        end
        if (advance) begin
            tmr_d.row = tmr_q.row + 1'b1;
        end
        if (!enable) begin
            tmr_d.cnt  = '0;
            tmr_d.pend = 1'b0;
        end else if (tmr_q.cnt == CW'(INTERVAL - 1)) begin
            tmr_d.cnt  = '0;
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pend    = tmr_q.pend;
    assign ref_row = tmr_q.row;

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int COL_W = 7,
    parameter int PIN_W = 7
) (
    input  pin_src_e         src,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] ref_row,
    output logic [PIN_W-1:0] pins
);
    always_comb begin
        unique case (src)
            PIN_ROW: pins = PIN_W'(row);
            PIN_COL: pins = PIN_W'(col);
            PIN_REF: pins = PIN_W'(ref_row);
            default: pins = '0;
        endcase
    end

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
    import dram_pkg::*;
#(
    parameter int ROW_W        = 7,
    parameter int COL_W        = 7,
    parameter int REF_INTERVAL = 64,
    parameter int REF_CYC      = 2,
    parameter int PRE_CYC      = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic                     rd_req,
    input  logic                     wr_req,
    input  logic [ROW_W+COL_W-1:0]   addr,
    input  logic                     auto_ref,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ram_addr,
    output logic                     ras_n,
    output logic                     cas_n,
    output logic                     we_n,
    output logic                     early_ack_n,
    output logic                     late_ack_n
);
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CNT_MAX = (REF_CYC > PRE_CYC) ? REF_CYC : PRE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        dram_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic             held;
        logic             after_acc;
    } ctl_t;

    ctl_t q, d;

    logic             req;
    logic             ref_pend;
    logic             ref_take;
    logic             ref_adv;
    logic [ROW_W-1:0] ref_row;
    pin_src_e         pin_src;

    assign req = sel && (rd_req || wr_req);

    always_comb begin
        d        = q;
        ref_take = 1'b0;
        ref_adv  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.after_acc = 1'b0;
                if (req && !(ref_pend && q.after_acc)) begin
                    d.st  = ST_ROW;
                    d.row = addr[ROW_W-1:0];
                    d.col = addr[ADDR_W-1:ROW_W];
                    d.wr  = wr_req;
                end else if (ref_pend) begin
                    d.st     = ST_REF;
                    d.cnt    = '0;
                    ref_take = 1'b1;
                end
            end
            ST_ROW: begin
                d.st = ST_COL;
            end
            ST_COL: begin
                d.st = ST_DATA;
            end
            ST_DATA: begin
                if (!req) begin
                    d.st  = ST_PRE;
                    d.cnt = '0;
                end
            end
            ST_PRE: begin
                if (q.cnt == CNT_W'(PRE_CYC - 1)) begin
                    d.st        = ST_IDLE;
                    d.after_acc = 1'b1;
                    d.held      = 1'b0;
                    d.wr        = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_REF: begin
                if (req) begin
                    d.held = 1'b1;
                end
                if (q.cnt == CNT_W'(REF_CYC - 1)) begin
                    d.st    = ST_REFPRE;
                    d.cnt   = '0;
                    ref_adv = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_REFPRE: begin
                if (q.cnt == CNT_W'(PRE_CYC - 1)) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    dram_ref_timer #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (ROW_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (auto_ref),
        .take    (ref_take),
        .advance (ref_adv),
        .pend    (ref_pend),
        .ref_row (ref_row)
    );

    always_comb begin
        unique case (q.st)
            ST_ROW:           pin_src = PIN_ROW;
            ST_COL, ST_DATA:  pin_src = PIN_COL;
            ST_REF:           pin_src = PIN_REF;
            default:          pin_src = PIN_NONE;
        endcase
    end

    dram_addr_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .PIN_W (PIN_W)
    ) u_mux (
        .src     (pin_src),
        .row     (q.row),
        .col     (q.col),
        .ref_row (ref_row),
        .pins    (ram_addr)
    );

    assign ras_n = !(q.st inside {ST_ROW, ST_COL, ST_DATA, ST_REF});
    assign cas_n = !(q.st inside {ST_COL, ST_DATA});
    assign we_n  = !(q.wr && (q.st inside {ST_ROW, ST_COL}));
    assign late_ack_n  = (q.st != ST_DATA);
    assign early_ack_n = !((q.st == ST_DATA) ||
                           (!q.held && (q.st inside {ST_ROW, ST_COL})));

endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk
    import dram_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     sel,
    input logic     rd_req,
    input logic     wr_req,
    input logic     ras_n,
    input logic     cas_n,
    input logic     we_n,
    input logic     early_ack_n,
    input logic     late_ack_n,
    input dram_st_e st,
    input logic     ref_pend,
    input logic     after_acc
);
    p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_we_before_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> $past(!we_n && !ras_n));

    p_late_with_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !late_ack_n |-> (!early_ack_n && !cas_n));

    p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!late_ack_n && !(sel && (rd_req || wr_req))) |=> (late_ack_n && early_ack_n && ras_n));

    p_no_start_unselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !sel) |=> (st != ST_ROW));

    p_refresh_ras_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REF) |-> (cas_n && we_n && early_ack_n && late_ack_n));

    p_ref_after_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && after_acc && ref_pend) |=> (st == ST_REF));

endmodule

bind dram_ctl dram_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .early_ack_n (early_ack_n),
    .late_ack_n  (late_ack_n),
    .st          (q.st),
    .ref_pend    (ref_pend),
    .after_acc   (q.after_acc)
);

// File: tb/dram_ctl_tb.sv
module dram_ctl_tb;
    localparam int INTERVAL = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [13:0] addr = '0;
    logic        auto_ref = 1'b1;
    logic [6:0]  ram_addr;
    logic        ras_n, cas_n, we_n, early_ack_n, late_ack_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    dram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_req(rd_req), .wr_req(wr_req),
        .addr(addr), .auto_ref(auto_ref), .ram_addr(ram_addr), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .early_ack_n(early_ack_n), .late_ack_n(late_ack_n)
    );

    function automatic int row_of(input logic [13:0] a);
        return int'(a[6:0]);
    endfunction

    function automatic int col_of(input logic [13:0] a);
        return int'(a[13:7]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // refresh monitor (R8)
    logic prev_ras = 1'b1, prev_cas = 1'b1, in_ref = 1'b0;
    int   exp_ref_row = 0;
    int   ref_count = 0;
    int   last_start = -1, prev_start = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!ras_n && cas_n && !prev_ras && prev_cas && !in_ref) begin
                in_ref = 1'b1;
                chk("R8 refresh row on pins", int'(ram_addr), exp_ref_row);
                chk("R8 refresh we_n high", int'(we_n), 1);
                exp_ref_row = (exp_ref_row + 1) % 128;
                ref_count++;
                prev_start = last_start;
                last_start = cyc - 1;
            end
            if (ras_n) in_ref = 1'b0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic do_acc(input logic [13:0] a, input bit wr, input int hold);
        int  n_low = 0;
        int  guard = 0;
        logic l_ras, l_we, l_early, pp_ras;
        logic [6:0] l_addr;
        bit held_exp;
        @(negedge clk);
        l_ras = ras_n; l_we = we_n; l_early = early_ack_n; l_addr = ram_addr; pp_ras = 1'b1;
        if (!ras_n) n_low++;
        sel = 1'b1; rd_req = !wr; wr_req = wr; addr = a;
        forever begin
            @(negedge clk);
            guard++;
            if (!cas_n || guard > 300) break;
            pp_ras = l_ras;
            l_ras = ras_n; l_we = we_n; l_early = early_ack_n; l_addr = ram_addr;
            if (!ras_n) n_low++;
        end
        held_exp = (n_low > 1);
        chk("R1 row cycle ras_n low", int'(l_ras), 0);
        chk("R1 row on pins", int'(l_addr), row_of(a));
        chk("R10 ras_n high before row cycle", int'(pp_ras), 1);
        chk("R3 we_n in row cycle", int'(l_we), wr ? 0 : 1);
        chk("R4 early ack in row cycle", int'(l_early), held_exp ? 1 : 0);
        chk("R2 column on pins", int'(ram_addr), col_of(a));
        chk("R2 ras_n low in column cycle", int'(ras_n), 0);
        chk("R3 we_n in column cycle", int'(we_n), wr ? 0 : 1);
        chk("R4 early ack in column cycle", int'(early_ack_n), held_exp ? 1 : 0);
        chk("R5 late ack high in column cycle", int'(late_ack_n), 1);
        @(negedge clk);
        chk("R5 late ack low third cycle", int'(late_ack_n), 0);
        chk("R4 early ack low with late", int'(early_ack_n), 0);
        chk("R3 we_n high third cycle", int'(we_n), 1);
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            chk("R5 acks held", int'({late_ack_n, early_ack_n, cas_n}), 0);
        end
        rd_req = 1'b0; wr_req = 1'b0;
        @(negedge clk);
        chk("R6 acks release", int'({late_ack_n, early_ack_n, ras_n, cas_n}), 15);
    endtask

    initial begin
        int base;
        int s0;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R6 reset outputs high", int'({ras_n, cas_n, we_n, early_ack_n, late_ack_n}), 31);
        chk("R1 reset pins zero", int'(ram_addr), 0);
        rst_n = 1'b1;

        // directed read and write
        do_acc(14'h3A55, 1'b0, 1);
        do_acc(14'h0001, 1'b1, 3);
        do_acc(14'h3FFF, 1'b1, 1);
        do_acc(14'h0000, 1'b0, 2);

        // R8 refresh spacing while idle
        @(negedge clk); sel = 1'b0;
        repeat (3 * INTERVAL) @(negedge clk);
        chk("R8 refresh spacing", last_start - prev_start, INTERVAL);

        // R9 refresh disabled
        auto_ref = 1'b0;
        repeat (4) @(negedge clk);
        base = ref_count;
        repeat (3 * INTERVAL) @(negedge clk);
        chk("R9 no refresh when disabled", ref_count - base, 0);

        // R7 chip select low ignores requests
        sel = 1'b0; rd_req = 1'b1; addr = 14'h1234;
        s0 = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!ras_n || !early_ack_n) s0++;
        end
        chk("R7 no activity while unselected", s0, 0);
        rd_req = 1'b0;
        do_acc(14'h1234, 1'b0, 1);
        auto_ref = 1'b1;

        // R11 back-to-back traffic still refreshes
        base = ref_count;
        for (int i = 0; i < 60; i++) begin
            do_acc(14'($urandom), 1'($urandom), 1);
        end
        chk("R11 refresh under continuous traffic", int'(ref_count - base >= 3), 1);

        // random mix
        for (int i = 0; i < 200; i++) begin
            do_acc(14'($urandom), 1'($urandom), 1 + int'($urandom % 4));
            sel = 1'($urandom % 4 != 0);
            repeat ($urandom % 21) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        report();
        $finish;
    end

endmodule